// File: doc/BRIEF.md
# LPM L1 Sleep Depth Controller

This block picks how far a USB 2.0 device powers down while its link sits in the L1 low-power state. When an L1 entry is signalled, it compares the 4-bit HIRD value carried by the LPM token with a 5-bit programmed threshold. The low four bits of the threshold are the compare value. The top bit allows deep mode at all. From that comparison the block latches one of two power depths. It then drives one of two active-low PHY controls for as long as L1 lasts: deep suspend or shallow sleep.

When keep-connect and L1 hibernation are both enabled and the HIRD value exceeds the compare value, the block also emits a one-cycle hibernation request. It then holds the link in L1 and ignores host exit attempts. Only a link state request carrying the Recovery code, written by software, releases the link. In SuperSpeed mode the threshold is treated as zero, so deep suspend is never chosen.

Top module: `l1_depth_ctrl`

## Requirements
- R1: After reset, in_l1_o is 0, deep_susp_no and sleep_no are both 1, and hib_req_o is 0.
- R2: A pulse on l1_enter_i while not in L1 sets in_l1_o one cycle later. Deep suspend is chosen (deep_susp_no=0, sleep_no=1) when thresh_i[4]=1 and hird_i >= thresh_i[3:0], the equal case included.
- R3: On L1 entry, shallow sleep is chosen (sleep_no=0, deep_susp_no=1) when hird_i < thresh_i[3:0] or thresh_i[4]=0.
- R4: While in L1 exactly one of deep_susp_no and sleep_no is 0. Outside L1 both are 1.
- R5: The depth choice is latched at entry. Changes to hird_i or thresh_i during L1 do not alter the outputs.
- R6: hib_req_o pulses high for exactly one cycle, in the same cycle in_l1_o first rises. It does so only when keep_conn_i=1, l1_hib_en_i=1 and hird_i > thresh_i[3:0] (strictly) at entry.
- R7: In L1 without a hibernation request, l1_exit_i=1, or a Recovery write (link_req_we_i=1 with link_req_i=4'd8), clears in_l1_o one cycle later.
- R8: After a hibernation request, l1_exit_i is ignored. A link_req_we_i write with any code other than 4'd8 is also ignored. Only a write of 4'd8 leaves L1.
- R9: With ss_mode_i=1 the threshold is taken as zero. Shallow sleep is always chosen, and the hibernation condition becomes hird_i > 0.
- R10: l1_enter_i while already in L1 changes nothing. A Recovery write while not in L1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hird_i | input | 4 | HIRD value from the LPM token |
| l1_enter_i | input | 1 | L1 entry strobe |
| l1_exit_i | input | 1 | Host request to leave L1 |
| thresh_i | input | 5 | [4] deep-mode allow, [3:0] compare value |
| keep_conn_i | input | 1 | Keep-connect enable |
| l1_hib_en_i | input | 1 | L1 hibernation enable |
| ss_mode_i | input | 1 | SuperSpeed operation flag |
| link_req_we_i | input | 1 | Link state request write strobe |
| link_req_i | input | 4 | Link state request code, 4'd8 = Recovery |
| in_l1_o | output | 1 | Link is held in L1 |
| deep_susp_no | output | 1 | PHY deep suspend, active low |
| sleep_no | output | 1 | PHY shallow sleep, active low |
| hib_req_o | output | 1 | Hibernation request pulse |

## Verification
The hardest situation to reach is the hibernation hold with a host exit arriving during it. That requires keep-connect, hibernation enable and a HIRD strictly above the compare value, all at the same entry edge. The bench sets up that entry, then drives l1_exit_i and a non-Recovery code write while the link is held, and only then writes 4'd8. A behavioural model is compared every cycle. Directed checks sample the boundaries: HIRD equal to the compare value, and the SuperSpeed override.

// File: rtl/l1_depth_pkg.sv
package l1_depth_pkg;
  typedef enum logic [1:0] {
    L1_OFF  = 2'd0,
    L1_ON   = 2'd1,
    L1_HOLD = 2'd2
  } l1_st_e;
endpackage

// File: rtl/l1_depth_decide.sv
module l1_depth_decide #(
  parameter int HIRD_W = 4,
  localparam int THR_W = HIRD_W + 1
) (
  input  logic [HIRD_W-1:0] hird_i,
  input  logic [THR_W-1:0]  thresh_i,
  input  logic              ss_mode_i,
  input  logic              keep_conn_i,
  input  logic              l1_hib_en_i,
  output logic              go_deep_o,
  output logic              want_hib_o
);
  logic [THR_W-1:0] thr_eff;

  // threshold has no meaning in SuperSpeed: force it to zero
  assign thr_eff    = ss_mode_i ? '0 : thresh_i;
  assign go_deep_o  = thr_eff[THR_W-1] && (hird_i >= thr_eff[HIRD_W-1:0]);
  assign want_hib_o = keep_conn_i && l1_hib_en_i && (hird_i > thr_eff[HIRD_W-1:0]);
endmodule

// File: rtl/l1_depth_fsm.sv
module l1_depth_fsm
  import l1_depth_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic exit_i,
  input  logic recov_i,
  input  logic go_deep_i,
  input  logic want_hib_i,
  output logic in_l1_o,
  output logic deep_o,
  output logic hib_o
);
  l1_st_e st_q, st_d;
  logic   deep_q, deep_d;
  logic   hib_q, hib_d;

  always_comb begin
    st_d   = st_q;
    deep_d = deep_q;
    hib_d  = 1'b0;
    unique case (st_q)
      L1_OFF: if (enter_i) begin
        st_d   = want_hib_i ? L1_HOLD : L1_ON;
        deep_d = go_deep_i;
        hib_d  = want_hib_i;
      end
      L1_ON:   if (exit_i || recov_i) st_d = L1_OFF;
      L1_HOLD: if (recov_i) st_d = L1_OFF;  // host exit ignored here
      default: st_d = L1_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= L1_OFF;
      deep_q <= 1'b0;
      hib_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      deep_q <= deep_d;
      hib_q  <= hib_d;
    end
  end

  assign in_l1_o = (st_q != L1_OFF);
  assign deep_o  = deep_q;
  assign hib_o   = hib_q;
endmodule

// File: rtl/l1_phy_drive.sv
module l1_phy_drive (
  input  logic in_l1_i,
  input  logic deep_i,
  output logic deep_susp_no,
  output logic sleep_no
);
  assign deep_susp_no = ~(in_l1_i & deep_i);
  assign sleep_no     = ~(in_l1_i & ~deep_i);
endmodule

// File: rtl/l1_depth_ctrl.sv
module l1_depth_ctrl #(
  parameter int              HIRD_W     = 4,
  parameter int              LNK_W      = 4,
  parameter logic [LNK_W-1:0] RECOV_CODE = 4'd8,
  localparam int             THR_W      = HIRD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIRD_W-1:0] hird_i,
  input  logic              l1_enter_i,
  input  logic              l1_exit_i,
  input  logic [THR_W-1:0]  thresh_i,
  input  logic              keep_conn_i,
  input  logic              l1_hib_en_i,
  input  logic              ss_mode_i,
  input  logic              link_req_we_i,
  input  logic [LNK_W-1:0]  link_req_i,
  output logic              in_l1_o,
  output logic              deep_susp_no,
  output logic              sleep_no,
  output logic              hib_req_o
);
  logic go_deep, want_hib, recov, deep_q;

  assign recov = link_req_we_i && (link_req_i == RECOV_CODE);

  l1_depth_decide #(.HIRD_W(HIRD_W)) u_decide (
    .hird_i      (hird_i),
    .thresh_i    (thresh_i),
    .ss_mode_i   (ss_mode_i),
    .keep_conn_i (keep_conn_i),
    .l1_hib_en_i (l1_hib_en_i),
    .go_deep_o   (go_deep),
    .want_hib_o  (want_hib)
  );

  l1_depth_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enter_i    (l1_enter_i),
    .exit_i     (l1_exit_i),
    .recov_i    (recov),
    .go_deep_i  (go_deep),
    .want_hib_i (want_hib),
    .in_l1_o    (in_l1_o),
    .deep_o     (deep_q),
    .hib_o      (hib_req_o)
  );

  l1_phy_drive u_drive (
    .in_l1_i      (in_l1_o),
    .deep_i       (deep_q),
    .deep_susp_no (deep_susp_no),
    .sleep_no     (sleep_no)
  );
endmodule

// File: rtl/l1_depth_chk.sv
module l1_depth_chk #(
  parameter int              HIRD_W     = 4,
  parameter int              LNK_W      = 4,
  parameter logic [LNK_W-1:0] RECOV_CODE = 4'd8,
  localparam int             THR_W      = HIRD_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HIRD_W-1:0] hird_i,
  input logic              l1_enter_i,
  input logic              l1_exit_i,
  input logic [THR_W-1:0]  thresh_i,
  input logic              keep_conn_i,
  input logic              l1_hib_en_i,
  input logic              ss_mode_i,
  input logic              link_req_we_i,
  input logic [LNK_W-1:0]  link_req_i,
  input logic              in_l1_o,
  input logic              deep_susp_no,
  input logic              sleep_no,
  input logic              hib_req_o
);
  logic hold_q, recov;
  assign recov = link_req_we_i && (link_req_i == RECOV_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else if (hib_req_o) hold_q <= 1'b1;
    else if (!in_l1_o) hold_q <= 1'b0;
  end

  // R4
  one_low_in_l1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_l1_o |-> ($countones({deep_susp_no, sleep_no}) == 1));
  // R4
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_l1_o |-> (deep_susp_no && sleep_no));
  // R2
  enter_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_enter_i && !in_l1_o) |=> in_l1_o);
  // R6
  hib_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hib_req_o |=> !hib_req_o);
  // R6
  hib_in_l1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hib_req_o |-> (in_l1_o && $rose(in_l1_o)));
  // R5
  depth_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_l1_o && $past(in_l1_o)) |-> $stable(deep_susp_no));
  // R8
  hold_until_recov_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hold_q || hib_req_o) && in_l1_o && !recov) |=> in_l1_o);
  // R7
  exit_leaves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_l1_o && !hold_q && !hib_req_o && l1_exit_i) |=> !in_l1_o);

  logic unused_ok;
  assign unused_ok = ^{hird_i, thresh_i, keep_conn_i, l1_hib_en_i, ss_mode_i};
endmodule

bind l1_depth_ctrl l1_depth_chk #(
  .HIRD_W(HIRD_W), .LNK_W(LNK_W), .RECOV_CODE(RECOV_CODE)
) u_chk (.*);

// File: tb/tb_l1_depth_ctrl.sv
`timescale 1ns/1ps
module tb_l1_depth_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] hird = '0;
  logic       enter = 1'b0, exit_r = 1'b0;
  logic [4:0] thr = '0;
  logic       keep = 1'b0, hen = 1'b0, ss = 1'b0;
  logic       we = 1'b0;
  logic [3:0] code = '0;
  logic       in_l1, deep_n, sleep_n, hib;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  bit m_l1 = 0, m_deep = 0, m_hold = 0, m_hib = 0;

  always #2.5 clk = ~clk;

  l1_depth_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .hird_i(hird), .l1_enter_i(enter),
    .l1_exit_i(exit_r), .thresh_i(thr), .keep_conn_i(keep), .l1_hib_en_i(hen),
    .ss_mode_i(ss), .link_req_we_i(we), .link_req_i(code),
    .in_l1_o(in_l1), .deep_susp_no(deep_n), .sleep_no(sleep_n), .hib_req_o(hib)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_l1 = 0; m_deep = 0; m_hold = 0; m_hib = 0;
    end else begin
      int t_cmp, t_top;
      m_hib = 0;
      t_cmp = ss ? 0 : int'(thr[3:0]);
      t_top = ss ? 0 : int'(thr[4]);
      if (!m_l1) begin
        if (enter) begin
          m_l1   = 1;
          m_deep = (t_top == 1) && (int'(hird) >= t_cmp);
          m_hold = keep && hen && (int'(hird) > t_cmp);
          m_hib  = m_hold;
        end
      end else begin
        bit rec;
        rec = we && (code == 4'd8);
        if (m_hold ? rec : (exit_r || rec)) begin
          m_l1 = 0; m_hold = 0;
        end
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(in_l1 == m_l1, "R2/R7 in_l1", in_l1, m_l1);
      chk(deep_n == !(m_l1 && m_deep), "R2/R4 deep_susp_n", deep_n, !(m_l1 && m_deep));
      chk(sleep_n == !(m_l1 && !m_deep), "R3/R4 sleep_n", sleep_n, !(m_l1 && !m_deep));
      chk(hib == m_hib, "R6 hib_req", hib, m_hib);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_enter(input logic [3:0] h, input logic [4:0] t);
    @(negedge clk); hird = h; thr = t; enter = 1'b1;
    @(negedge clk); enter = 1'b0;
  endtask

  task automatic do_exit();
    @(negedge clk); exit_r = 1'b1;
    @(negedge clk); exit_r = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] c);
    @(negedge clk); we = 1'b1; code = c;
    @(negedge clk); we = 1'b0; code = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_l1 == 0 && deep_n == 1 && sleep_n == 1 && hib == 0, "R1 reset",
        {in_l1, deep_n, sleep_n, hib}, 4'b0110);
    rst_n = 1'b1;
    idle(2);

    // R2 deep at equality boundary
    do_enter(4'd5, 5'b1_0101);
    chk(deep_n == 0 && sleep_n == 1, "R2 deep at hird==cmp", {deep_n, sleep_n}, 2'b01);
    do_exit();
    chk(in_l1 == 0, "R7 exit leaves", in_l1, 0);

    // R3 hird below compare
    do_enter(4'd4, 5'b1_0101);
    chk(sleep_n == 0 && deep_n == 1, "R3 below cmp", {deep_n, sleep_n}, 2'b10);
    do_write(4'd8);
    chk(in_l1 == 0, "R7 recovery leaves", in_l1, 0);

    // R3 deep not allowed
    do_enter(4'd15, 5'b0_0000);
    chk(sleep_n == 0 && deep_n == 1, "R3 top bit clear", {deep_n, sleep_n}, 2'b10);
    do_exit();
    chk(deep_n == 1 && sleep_n == 1, "R4 both high after exit", {deep_n, sleep_n}, 2'b11);

    // R5 latched choice
    do_enter(4'd9, 5'b1_0010);
    @(negedge clk); thr = 5'b0_1111; hird = 4'd0;
    idle(2);
    chk(deep_n == 0 && sleep_n == 1, "R5 latched", {deep_n, sleep_n}, 2'b01);
    // R10 re-entry ignored
    do_enter(4'd0, 5'b0_0000);
    chk(deep_n == 0 && in_l1 == 1, "R10 enter in L1 ignored", {in_l1, deep_n}, 2'b10);
    do_exit();

    // R10 recovery outside L1
    do_write(4'd8);
    chk(in_l1 == 0, "R10 recovery idle ignored", in_l1, 0);

    // R6 / R8 hibernation hold
    keep = 1'b1; hen = 1'b1;
    @(negedge clk); hird = 4'd4; thr = 5'b1_0011; enter = 1'b1;
    @(negedge clk); enter = 1'b0;
    chk(hib == 1 && in_l1 == 1, "R6 hib pulse", {in_l1, hib}, 2'b11);
    @(negedge clk);
    chk(hib == 0, "R6 single cycle", hib, 0);
    do_exit();
    chk(in_l1 == 1, "R8 exit ignored in hold", in_l1, 1);
    do_write(4'd5);
    chk(in_l1 == 1, "R8 non-recovery ignored", in_l1, 1);
    do_write(4'd8);
    chk(in_l1 == 0, "R8 recovery releases", in_l1, 0);

    // R6 equal -> no hibernation
    @(negedge clk); hird = 4'd3; thr = 5'b1_0011; enter = 1'b1;
    @(negedge clk); enter = 1'b0;
    chk(hib == 0, "R6 equal no hib", hib, 0);
    do_exit();
    chk(in_l1 == 0, "R7 exit without hold", in_l1, 0);

    // R6 keep-connect off
    keep = 1'b0;
    @(negedge clk); hird = 4'd12; thr = 5'b1_0001; enter = 1'b1;
    @(negedge clk); enter = 1'b0;
    chk(hib == 0, "R6 keep off no hib", hib, 0);
    do_exit();

    // R9 SuperSpeed override
    keep = 1'b1; ss = 1'b1;
    @(negedge clk); hird = 4'd15; thr = 5'b1_0000; enter = 1'b1;
    @(negedge clk); enter = 1'b0;
    chk(sleep_n == 0 && deep_n == 1, "R9 ss forces sleep", {deep_n, sleep_n}, 2'b10);
    chk(hib == 1, "R9 ss hib hird>0", hib, 1);
    do_write(4'd8);
    @(negedge clk); hird = 4'd0; enter = 1'b1;
    @(negedge clk); enter = 1'b0;
    chk(hib == 0, "R9 ss hird zero no hib", hib, 0);
    do_exit();
    chk(in_l1 == 0, "R9 ss exit", in_l1, 0);
    ss = 1'b0; keep = 1'b0; hen = 1'b0;

    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule